// File: doc/BRIEF.md
# Tile Video Host Register Port

This block is the host-facing side of a tile video controller. A byte-wide host bus with four port addresses reaches a bank of 32 sixteen-bit control registers. Port 0 picks the register index on a write and returns the event status byte on a read. Ports 2 and 3 carry the low and high byte of the picked register. Every register is visible in parallel to the rest of the controller. Rendering, timing and the DMA engines are outside this block. They read the register values and react to single-cycle trigger pulses.

Two registers form a word-wide window onto a single-port 32K x 16 video memory. Writing the high byte of the data register stores the whole word at the write-address register. That address then advances by a step chosen in the control register. Reads go through a prefetch buffer. The buffer loads when the high byte of the read-address register is written. When the data register is selected, each high-byte read advances the read address and reloads the buffer. The status byte collects event bits from the rest of the chip. Reading it clears it and drops the interrupt line.

The sequencer has five states, named S_IDLE, S_WRITE, S_FETCH, S_FILL and S_DONE. Any accepted request in S_IDLE moves to S_DONE, except for two cases:
- A high-byte write to the data register moves to S_WRITE, then to S_DONE.
- A high-byte write to the read-address register, or a high-byte read with the data register selected, moves to S_FETCH. It then passes through S_FILL and on to S_DONE.

S_DONE raises `bus_ready` for one cycle and always returns to S_IDLE. A request is a one-cycle `bus_req` pulse. Further pulses before `bus_ready` are ignored.

Top module: `tile_video_host_port`

## Requirements
- R1: A port-0 write (`bus_port` = 0) stores bits 4:0 of `bus_wdata` as the selected register index, and the upper data bits are ignored.
- R2: A port-2 write replaces only bits 7:0 of the selected register, and a port-3 write replaces only bits 15:8.
- R3: A port-3 write with register 2 selected writes the full register-2 value to video memory at the address held in register 0. Register 0 then grows by the step.
- R4: The step is set by bits 12:11 of register 5: code 0 gives 1, code 1 gives 32, code 2 gives 64 and code 3 gives 128.
- R5: A memory write whose register-0 address is 0x8000 or above issues no memory write, but register 0 still grows by the step.
- R6: A port-3 write to register 1 loads the read buffer with memory word (register 1 AND 0x7FFF). A port-2 write to register 1 leaves the buffer unchanged.
- R7: A port-2 read returns buffer bits 7:0, a port-3 read returns buffer bits 15:8, and a port-1 read returns 0.
- R8: A port-3 read with register 2 selected returns the old buffer high byte. Register 1 then grows by the step and the buffer reloads from the new address. With another register selected, a port-3 read changes nothing.
- R9: `status_set` bits are ORed into the status byte, and any nonzero `status_set` raises `irq`. A port-0 read returns the status byte, then clears it and drops `irq`. Bits set in the same cycle as that read survive it.
- R10: Any byte write to register 7 leaves it masked to 10 bits, and any byte write to register 8 leaves it masked to 9 bits. Every byte write to register 8 pulses `yscroll_upd` for one cycle.
- R11: A port-3 write to register 18 pulses `blk_dma_go`, and a port-3 write to register 19 pulses `tbl_dma_go`. Each pulse lasts one cycle, and low-byte writes pulse neither.
- R12: After reset, register 10 is 0x00FF, register 11 is 0x001F, register 13 is 0x01FF, registers 12 and 14 are 0xFFFF, and all other registers are 0. The read buffer is 0xFFFF and `irq` is low.
- R13: `bus_ready` rises one cycle after a plain request, two cycles after a memory write and three cycles after a buffer fetch. It stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | One-cycle request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_port | input | 2 | Port address 0..3 |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid with bus_ready |
| bus_ready | output | 1 | Request complete |
| status_set | input | 8 | Event bits to merge into status |
| irq | output | 1 | Interrupt line |
| vram_addr | output | 15 | Video memory word address |
| vram_we | output | 1 | Video memory write enable |
| vram_re | output | 1 | Video memory read enable, data one cycle later |
| vram_wdata | output | 16 | Video memory write word |
| vram_rdata | input | 16 | Video memory read word |
| reg_view | output | 512 | All registers, register n at bits 16n+15:16n |
| blk_dma_go | output | 1 | Block-copy start pulse |
| tbl_dma_go | output | 1 | Table-copy request pulse |
| yscroll_upd | output | 1 | Vertical scroll update pulse |

## Verification
Two functions can land in the same clock edge. One is a status-clearing port-0 read and the other is a `status_set` event from outside. The bench pulses `status_set` in the same cycle it issues the port-0 read. It then checks that the read returned only the earlier bits, that `irq` is still high, and that a second read returns the newly set bit. The bench also sweeps all four step codes for the write path and for the advancing read path. It judges each memory access and register value against addresses computed from the step arithmetic, including the step that crosses the 0x8000 boundary.

// File: rtl/thv_pkg.sv
package thv_pkg;

    // Register indices whose behaviour is decoded inside the block
    localparam int IDX_WADDR = 0;
    localparam int IDX_RADDR = 1;
    localparam int IDX_VDATA = 2;
    localparam int IDX_CTRL  = 5;
    localparam int IDX_XSCR  = 7;
    localparam int IDX_YSCR  = 8;
    localparam int IDX_BDMA  = 18;
    localparam int IDX_TDMA  = 19;

    // Step-code field position inside the control register
    localparam int INC_LSB   = 11;

    // Scroll register widths after masking
    localparam int XSCR_BITS = 10;
    localparam int YSCR_BITS = 9;

    // Host port addresses
    localparam logic [1:0] PORT_SEL  = 2'd0;
    localparam logic [1:0] PORT_NONE = 2'd1;
    localparam logic [1:0] PORT_LO   = 2'd2;
    localparam logic [1:0] PORT_HI   = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_FETCH,
        S_FILL,
        S_DONE
    } seq_state_e;

    function automatic logic [15:0] reg_reset_value(input int idx);
        case (idx)
            10:      return 16'h00FF;
            11:      return 16'h001F;
            13:      return 16'h01FF;
            12, 14:  return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/thv_regfile.sv
module thv_regfile
    import thv_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 16,
    parameter int BW       = 8,
    parameter int IDX_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [IDX_W-1:0]          idx,
    input  logic [BW-1:0]             wbyte,
    input  logic                      adv_wr,
    input  logic                      adv_rd,
    output logic [NUM_REGS*REG_W-1:0] regs_flat,
    output logic [REG_W-1:0]          step
);

    localparam int HI_W = REG_W - BW;
    localparam logic [REG_W-1:0] XMASK = REG_W'((1 << XSCR_BITS) - 1);
    localparam logic [REG_W-1:0] YMASK = REG_W'((1 << YSCR_BITS) - 1);

    logic [1:0] step_code;

    assign step_code = regs_flat[IDX_CTRL*REG_W + INC_LSB +: 2];

    always_comb begin
        unique case (step_code)
            2'd0: step = REG_W'(1);
            2'd1: step = REG_W'(32);
            2'd2: step = REG_W'(64);
            2'd3: step = REG_W'(128);
            default: step = REG_W'(1);
        endcase
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] q;
        logic [REG_W-1:0] nxt;
        logic             hit_lo;
        logic             hit_hi;

        assign hit_lo = wr_lo && (idx == IDX_W'(g));
        assign hit_hi = wr_hi && (idx == IDX_W'(g));

        always_comb begin
            nxt = q;
            if (hit_lo) begin
                nxt[BW-1:0] = wbyte;
            end
            if (hit_hi) begin
                nxt[REG_W-1:BW] = HI_W'(wbyte);
            end
            if ((g == IDX_XSCR) && (hit_lo || hit_hi)) begin
                nxt = nxt & XMASK;
            end
            if ((g == IDX_YSCR) && (hit_lo || hit_hi)) begin
                nxt = nxt & YMASK;
            end
            if ((g == IDX_WADDR) && adv_wr) begin
                nxt = q + step;
            end
            if ((g == IDX_RADDR) && adv_rd) begin
                nxt = q + step;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= REG_W'(reg_reset_value(g));
            end else begin
                q <= nxt;
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = q;
    end

endmodule

// File: rtl/thv_status.sv
module thv_status #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] set_bits,
    input  logic          clr,
    output logic [BW-1:0] status,
    output logic          irq
);

    logic [BW-1:0] status_nxt;
    logic          irq_nxt;

    always_comb begin
        status_nxt = (clr ? '0 : status) | set_bits;
        irq_nxt    = (clr ? 1'b0 : irq) | (|set_bits);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_nxt;
            irq    <= irq_nxt;
        end
    end

endmodule

// File: rtl/thv_seq.sv
module thv_seq
    import thv_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int BW    = 8,
    parameter int AW    = 15,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [1:0]       bus_port,
    input  logic [BW-1:0]    bus_wdata,
    output logic             bus_ready,
    output logic [BW-1:0]    bus_rdata,
    input  logic [REG_W-1:0] waddr,
    input  logic [AW-1:0]    raddr,
    input  logic [REG_W-1:0] vdata,
    input  logic [BW-1:0]    status,
    output logic             rf_wr_lo,
    output logic             rf_wr_hi,
    output logic [IDX_W-1:0] rf_idx,
    output logic [BW-1:0]    rf_wbyte,
    output logic             rf_adv_wr,
    output logic             rf_adv_rd,
    output logic             st_clr,
    output logic             vram_we,
    output logic             vram_re,
    output logic [AW-1:0]    vram_addr,
    output logic [REG_W-1:0] vram_wdata,
    input  logic [REG_W-1:0] vram_rdata,
    output logic             blk_dma_go,
    output logic             tbl_dma_go,
    output logic             yscroll_upd,
    output logic             idle
);

    seq_state_e      state_q;
    seq_state_e      state_d;
    logic [IDX_W-1:0] sel_q;
    logic [REG_W-1:0] rbuf_q;
    logic [BW-1:0]    rdata_q;
    logic             accept;
    logic             is_wr;
    logic             is_rd;
    logic             sel_is_data;
    logic             sel_is_raddr;
    logic             waddr_ok;

    assign accept       = (state_q == S_IDLE) && bus_req;
    assign is_wr        = accept && bus_we;
    assign is_rd        = accept && !bus_we;
    assign sel_is_data  = (sel_q == IDX_W'(IDX_VDATA));
    assign sel_is_raddr = (sel_q == IDX_W'(IDX_RADDR));
    assign waddr_ok     = ((waddr >> AW) == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and strobes
    always_comb begin
        state_d   = state_q;
        rf_wr_lo  = 1'b0;
        rf_wr_hi  = 1'b0;
        rf_adv_wr = 1'b0;
        rf_adv_rd = 1'b0;
        st_clr    = 1'b0;
        vram_we   = 1'b0;
        vram_re   = 1'b0;
        vram_addr = raddr;
        bus_ready = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    rf_wr_lo  = is_wr && (bus_port == PORT_LO);
                    rf_wr_hi  = is_wr && (bus_port == PORT_HI);
                    st_clr    = is_rd && (bus_port == PORT_SEL);
                    rf_adv_rd = is_rd && (bus_port == PORT_HI) && sel_is_data;
                    if (rf_wr_hi && sel_is_data) begin
                        state_d = S_WRITE;
                    end else if ((rf_wr_hi && sel_is_raddr) || rf_adv_rd) begin
                        state_d = S_FETCH;
                    end else begin
                        state_d = S_DONE;
                    end
                end
            end
            S_WRITE: begin
                vram_addr = waddr[AW-1:0];
                vram_we   = waddr_ok;
                rf_adv_wr = 1'b1;
                state_d   = S_DONE;
            end
            S_FETCH: begin
                vram_re = 1'b1;
                state_d = S_FILL;
            end
            S_FILL: begin
                state_d = S_DONE;
            end
            S_DONE: begin
                bus_ready = 1'b1;
                state_d   = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    assign rf_idx      = sel_q;
    assign rf_wbyte    = bus_wdata;
    assign vram_wdata  = vdata;
    assign bus_rdata   = rdata_q;
    assign idle        = (state_q == S_IDLE);

    // Datapath registers: index latch, prefetch buffer, read byte, pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q       <= '0;
            rbuf_q      <= '1;
            rdata_q     <= '0;
            blk_dma_go  <= 1'b0;
            tbl_dma_go  <= 1'b0;
            yscroll_upd <= 1'b0;
        end else begin
            if (is_wr && (bus_port == PORT_SEL)) begin
                sel_q <= bus_wdata[IDX_W-1:0];
            end
            if (state_q == S_FILL) begin
                rbuf_q <= vram_rdata;
            end
            if (is_rd) begin
                unique case (bus_port)
                    PORT_SEL:  rdata_q <= status;
                    PORT_NONE: rdata_q <= '0;
                    PORT_LO:   rdata_q <= rbuf_q[BW-1:0];
                    PORT_HI:   rdata_q <= BW'(rbuf_q >> BW);
                    default:   rdata_q <= '0;
                endcase
            end
            blk_dma_go  <= rf_wr_hi && (sel_q == IDX_W'(IDX_BDMA));
            tbl_dma_go  <= rf_wr_hi && (sel_q == IDX_W'(IDX_TDMA));
            yscroll_upd <= (rf_wr_lo || rf_wr_hi) && (sel_q == IDX_W'(IDX_YSCR));
        end
    end

endmodule

// File: rtl/tile_video_host_port.sv
module tile_video_host_port
    import thv_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 16,
    parameter int BW       = 8,
    parameter int AW       = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [1:0]                bus_port,
    input  logic [BW-1:0]             bus_wdata,
    output logic [BW-1:0]             bus_rdata,
    output logic                      bus_ready,
    input  logic [BW-1:0]             status_set,
    output logic                      irq,
    output logic [AW-1:0]             vram_addr,
    output logic                      vram_we,
    output logic                      vram_re,
    output logic [REG_W-1:0]          vram_wdata,
    input  logic [REG_W-1:0]          vram_rdata,
    output logic [NUM_REGS*REG_W-1:0] reg_view,
    output logic                      blk_dma_go,
    output logic                      tbl_dma_go,
    output logic                      yscroll_upd
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic             rf_wr_lo;
    logic             rf_wr_hi;
    logic [IDX_W-1:0] rf_idx;
    logic [BW-1:0]    rf_wbyte;
    logic             rf_adv_wr;
    logic             rf_adv_rd;
    logic [REG_W-1:0] step;
    logic             st_clr;
    logic [BW-1:0]    status_val;
    logic             host_idle;
    logic [REG_W-1:0] waddr;
    logic [AW-1:0]    raddr;
    logic [REG_W-1:0] vdata;

    assign waddr = reg_view[IDX_WADDR*REG_W +: REG_W];
    assign raddr = reg_view[IDX_RADDR*REG_W +: AW];
    assign vdata = reg_view[IDX_VDATA*REG_W +: REG_W];

    thv_regfile #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .BW       (BW),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo     (rf_wr_lo),
        .wr_hi     (rf_wr_hi),
        .idx       (rf_idx),
        .wbyte     (rf_wbyte),
        .adv_wr    (rf_adv_wr),
        .adv_rd    (rf_adv_rd),
        .regs_flat (reg_view),
        .step      (step)
    );

    thv_status #(
        .BW (BW)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (status_set),
        .clr      (st_clr),
        .status   (status_val),
        .irq      (irq)
    );

    thv_seq #(
        .REG_W (REG_W),
        .BW    (BW),
        .AW    (AW),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_port    (bus_port),
        .bus_wdata   (bus_wdata),
        .bus_ready   (bus_ready),
        .bus_rdata   (bus_rdata),
        .waddr       (waddr),
        .raddr       (raddr),
        .vdata       (vdata),
        .status      (status_val),
        .rf_wr_lo    (rf_wr_lo),
        .rf_wr_hi    (rf_wr_hi),
        .rf_idx      (rf_idx),
        .rf_wbyte    (rf_wbyte),
        .rf_adv_wr   (rf_adv_wr),
        .rf_adv_rd   (rf_adv_rd),
        .st_clr      (st_clr),
        .vram_we     (vram_we),
        .vram_re     (vram_re),
        .vram_addr   (vram_addr),
        .vram_wdata  (vram_wdata),
        .vram_rdata  (vram_rdata),
        .blk_dma_go  (blk_dma_go),
        .tbl_dma_go  (tbl_dma_go),
        .yscroll_upd (yscroll_upd),
        .idle        (host_idle)
    );

endmodule

// File: rtl/thv_checker.sv
module thv_checker #(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 16,
    parameter int BW       = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_req,
    input logic                      bus_we,
    input logic [1:0]                bus_port,
    input logic                      bus_ready,
    input logic                      vram_we,
    input logic                      vram_re,
    input logic                      blk_dma_go,
    input logic                      tbl_dma_go,
    input logic                      irq,
    input logic                      host_idle,
    input logic [BW-1:0]             status,
    input logic [BW-1:0]             status_set,
    input logic [NUM_REGS*REG_W-1:0] regs
);

    logic [REG_W-1:0] waddr;
    logic [REG_W-1:0] xscr;
    logic [REG_W-1:0] yscr;
    logic [1:0]       code;
    logic [REG_W-1:0] chk_step;

    assign waddr    = regs[0 +: REG_W];
    assign xscr     = regs[7*REG_W +: REG_W];
    assign yscr     = regs[8*REG_W +: REG_W];
    assign code     = regs[5*REG_W + 11 +: 2];
    assign chk_step = (code == 2'd0) ? REG_W'(1) : (REG_W'(16) << code);

    assert_write_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |=> (waddr == $past(waddr + chk_step)));

    assert_write_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> (waddr[REG_W-1] == 1'b0));

    assert_fetch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vram_re |=> !vram_re);

    assert_status_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_idle && bus_req && !bus_we && (bus_port == 2'd0) && (status_set == '0))
        |=> ((status == '0) && !irq));

    assert_xscroll_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((xscr >> 10) == '0));

    assert_yscroll_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((yscr >> 9) == '0));

    assert_dma_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_dma_go || tbl_dma_go) |=> !(blk_dma_go || tbl_dma_go));

    assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

endmodule

bind tile_video_host_port thv_checker #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .BW       (BW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_port   (bus_port),
    .bus_ready  (bus_ready),
    .vram_we    (vram_we),
    .vram_re    (vram_re),
    .blk_dma_go (blk_dma_go),
    .tbl_dma_go (tbl_dma_go),
    .irq        (irq),
    .host_idle  (host_idle),
    .status     (status_val),
    .status_set (status_set),
    .regs       (reg_view)
);

// File: tb/tile_video_host_port_tb_top.sv
`timescale 1ns/1ps
module tile_video_host_port_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_req;
    logic         bus_we;
    logic [1:0]   bus_port;
    logic [7:0]   bus_wdata;
    logic [7:0]   bus_rdata;
    logic         bus_ready;
    logic [7:0]   status_set;
    logic         irq;
    logic [14:0]  vram_addr;
    logic         vram_we;
    logic         vram_re;
    logic [15:0]  vram_wdata;
    logic [15:0]  vram_rdata;
    logic [511:0] reg_view;
    logic         blk_dma_go;
    logic         tbl_dma_go;
    logic         yscroll_upd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [14:0] last_wa;
    logic [15:0] last_wd;
    int          wcount;
    logic        p_blk;
    logic        p_tbl;
    logic        p_ysc;

    always #4 clk = ~clk;

    tile_video_host_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_port    (bus_port),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready),
        .status_set  (status_set),
        .irq         (irq),
        .vram_addr   (vram_addr),
        .vram_we     (vram_we),
        .vram_re     (vram_re),
        .vram_wdata  (vram_wdata),
        .vram_rdata  (vram_rdata),
        .reg_view    (reg_view),
        .blk_dma_go  (blk_dma_go),
        .tbl_dma_go  (tbl_dma_go),
        .yscroll_upd (yscroll_upd)
    );

    // Memory model: read data is a known function of the address
    function automatic logic [15:0] vfun(input logic [14:0] a);
        return ({1'b0, a} * 16'd3) ^ 16'hC35A;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            wcount     <= 0;
            last_wa    <= '0;
            last_wd    <= '0;
            vram_rdata <= '0;
        end else begin
            if (vram_re) vram_rdata <= vfun(vram_addr);
            if (vram_we) begin
                last_wa <= vram_addr;
                last_wd <= vram_wdata;
                wcount  <= wcount + 1;
            end
        end
    end

    function automatic logic [15:0] getr(input int i);
        return reg_view[i*16 +: 16];
    endfunction

    function automatic logic [15:0] exp_rst(input int i);
        if (i == 10) return 16'h00FF;
        if (i == 11) return 16'h001F;
        if (i == 13) return 16'h01FF;
        if (i == 12 || i == 14) return 16'hFFFF;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] step_of(input int c);
        return (c == 0) ? 16'd1 : (16'd16 << c);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request at a falling edge; returns read byte and latency
    task automatic op(input bit we, input logic [1:0] port, input logic [7:0] d,
                      input logic [7:0] sset, output logic [7:0] q, output int lat);
        bus_req    = 1'b1;
        bus_we     = we;
        bus_port   = port;
        bus_wdata  = d;
        status_set = sset;
        @(negedge clk);
        bus_req    = 1'b0;
        status_set = 8'h00;
        lat   = 1;
        p_blk = blk_dma_go;
        p_tbl = tbl_dma_go;
        p_ysc = yscroll_upd;
        while (!bus_ready && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        q = bus_rdata;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] port, input logic [7:0] d);
        logic [7:0] q;
        int lat;
        op(1'b1, port, d, 8'h00, q, lat);
    endtask

    task automatic wr16(input int idx, input logic [15:0] v);
        wr(2'd0, 8'(idx));
        wr(2'd2, v[7:0]);
        wr(2'd3, v[15:8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  q;
        int          lat;
        logic [15:0] v;
        logic [15:0] prev;
        logic [15:0] e;
        logic [15:0] base;
        int          cnt0;

        rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_port = 2'd0;
        bus_wdata = 8'h00; status_set = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset values of every register
        for (int i = 0; i < 32; i++) check($sformatf("R12 reset reg %0d", i), getr(i), exp_rst(i));
        check("R12 irq low after reset", irq, 1'b0);
        op(1'b0, 2'd2, 8'h00, 8'h00, q, lat);
        check("R12 R7 buffer low byte after reset", q, 8'hFF);
        check("R13 plain latency", lat, 1);
        op(1'b0, 2'd3, 8'h00, 8'h00, q, lat);
        check("R12 R7 buffer high byte after reset", q, 8'hFF);
        op(1'b0, 2'd1, 8'h00, 8'h00, q, lat);
        check("R7 port1 reads zero", q, 8'h00);

        // R1 R2 R10 R11: sweep of registers 3..31 with byte writes
        for (int i = 3; i < 32; i++) begin
            v = 16'(i * 16'h0101) ^ 16'h5A3C;
            wr(2'd0, 8'hE0 | 8'(i));
            prev = getr(i);
            op(1'b1, 2'd2, v[7:0], 8'h00, q, lat);
            e = {prev[15:8], v[7:0]};
            if (i == 7) e = e & 16'h03FF;
            if (i == 8) e = e & 16'h01FF;
            check($sformatf("R1 R2 low byte reg %0d", i), getr(i), e);
            check($sformatf("R10 yscroll pulse low reg %0d", i), p_ysc, (i == 8));
            check($sformatf("R11 no dma pulse on low byte reg %0d", i), {p_blk, p_tbl}, 2'b00);
            op(1'b1, 2'd3, v[15:8], 8'h00, q, lat);
            e = v;
            if (i == 7) e = e & 16'h03FF;
            if (i == 8) e = e & 16'h01FF;
            check($sformatf("R2 R10 high byte reg %0d", i), getr(i), e);
            check($sformatf("R11 block dma pulse reg %0d", i), p_blk, (i == 18));
            check($sformatf("R11 table dma pulse reg %0d", i), p_tbl, (i == 19));
            check($sformatf("R10 yscroll pulse high reg %0d", i), p_ysc, (i == 8));
        end

        // R3 R4: write path over all step codes
        for (int c = 0; c < 4; c++) begin
            wr16(5, 16'(c) << 11);
            base = 16'h0100 + 16'(c);
            wr16(0, base);
            for (int k = 0; k < 3; k++) begin
                v = 16'hA000 + 16'(c * 16 + k);
                wr(2'd0, 8'd2);
                wr(2'd2, v[7:0]);
                op(1'b1, 2'd3, v[15:8], 8'h00, q, lat);
                if (k == 0) check("R13 write latency", lat, 2);
                e = base + 16'(k) * step_of(c);
                check($sformatf("R3 write address code %0d", c), {17'h0, last_wa}, {16'h0, e});
                check($sformatf("R3 write data code %0d", c), last_wd, v);
                check($sformatf("R4 address step code %0d", c), getr(0), e + step_of(c));
            end
        end

        // R5: write past the memory end is dropped, address still moves
        wr16(5, 16'h1800);
        wr16(0, 16'h7FC0);
        cnt0 = wcount;
        wr16(2, 16'h1111);
        check("R5 write below limit lands", {17'h0, last_wa}, 32'h7FC0);
        check("R5 address after crossing", getr(0), 16'h8040);
        wr16(2, 16'h2222);
        check("R5 write above limit dropped", wcount, cnt0 + 1);
        check("R5 last write unchanged", last_wd, 16'h1111);
        check("R5 address still advances", getr(0), 16'h80C0);

        // R6: read address load fetches into the buffer
        wr(2'd0, 8'd1);
        wr(2'd2, 8'h34);
        op(1'b1, 2'd3, 8'h92, 8'h00, q, lat);
        check("R13 fetch latency", lat, 3);
        op(1'b0, 2'd2, 8'h00, 8'h00, q, lat);
        check("R6 R7 buffer low after load", q, vfun(15'h1234) & 16'h00FF);
        op(1'b0, 2'd3, 8'h00, 8'h00, q, lat);
        check("R6 R7 buffer high after load", q, vfun(15'h1234) >> 8);
        wr(2'd2, 8'h77);
        op(1'b0, 2'd2, 8'h00, 8'h00, q, lat);
        check("R6 low-byte write keeps buffer", q, vfun(15'h1234) & 16'h00FF);

        // R8: advancing reads over all step codes
        for (int c = 0; c < 4; c++) begin
            wr16(5, 16'(c) << 11);
            wr16(1, 16'h0200);
            wr(2'd0, 8'd2);
            op(1'b0, 2'd3, 8'h00, 8'h00, q, lat);
            check($sformatf("R8 old high byte code %0d", c), q, vfun(15'h0200) >> 8);
            check($sformatf("R8 read latency code %0d", c), lat, 3);
            check($sformatf("R8 read address advanced code %0d", c), getr(1), 16'h0200 + step_of(c));
            e = vfun(15'(16'h0200 + step_of(c)));
            op(1'b0, 2'd2, 8'h00, 8'h00, q, lat);
            check($sformatf("R8 refilled low byte code %0d", c), q, e & 16'h00FF);
            wr(2'd0, 8'd3);
            op(1'b0, 2'd3, 8'h00, 8'h00, q, lat);
            check($sformatf("R8 other select no advance code %0d", c), getr(1), 16'h0200 + step_of(c));
            check($sformatf("R8 other select high byte code %0d", c), q, e >> 8);
        end

        // R9: status merge, read-to-clear and same-cycle set
        status_set = 8'h24;
        @(negedge clk);
        status_set = 8'h00;
        check("R9 irq raised by event", irq, 1'b1);
        op(1'b0, 2'd0, 8'h00, 8'h00, q, lat);
        check("R9 status read value", q, 8'h24);
        check("R9 irq dropped after read", irq, 1'b0);
        op(1'b0, 2'd0, 8'h00, 8'h00, q, lat);
        check("R9 status cleared", q, 8'h00);
        status_set = 8'h04;
        @(negedge clk);
        status_set = 8'h00;
        op(1'b0, 2'd0, 8'h00, 8'h10, q, lat);
        check("R9 concurrent read returns older bits", q, 8'h04);
        check("R9 concurrent event keeps irq", irq, 1'b1);
        op(1'b0, 2'd0, 8'h00, 8'h00, q, lat);
        check("R9 concurrent event bit survives", q, 8'h10);
        check("R9 irq dropped at end", irq, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule